// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for one DMA channel. Software-facing logic outside the block supplies a start address, an element count and a signed byte stride for the inner loop (one row), and an element count and signed byte stride for the outer loop. It also supplies an element size, a one- or two-dimensional selector, a circular or single-shot selector and two interrupt enables. A start pulse captures this configuration. The block then offers one address per element on a valid/ready handshake until the programmed pattern is complete.

Within a row, the address moves by the inner stride after each accepted element. The last element of a row is followed by the outer stride, which replaces the inner stride rather than adding to it. Because both strides are signed and may be zero, the same engine covers plain copies, transposes and rotations (negative outer stride), fills from one location (zero inner stride) and scatter of interleaved streams.

In circular mode the channel reloads its start address and counts on the final element and keeps going with no idle cycle. In single-shot mode it stops, raises done and holds its last address. Data movement, bus protocol, descriptor fetch and arbitration live elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, addr_valid, busy, done, err, irq_row and irq_end are all low.
- R2: A start while not busy is rejected when the inner count is zero, when the outer count is zero in two-dimensional mode, or when the size code is 3. A rejected start sets err, leaves busy and addr_valid low, and keeps the other state. The next accepted start clears err.
- R3: One cycle after an accepted start, busy is high, addr equals the start address, and addr_size carries the size code (0 = 8 bit, 1 = 16 bit, 2 = 32 bit). Strides stay byte offsets whatever the size.
- R4: Between consecutive elements of one row, the address changes by the sign-extended inner stride. A zero stride repeats the same address.
- R5: After the last element of a row that is not the final row, the next address is the previous address plus the sign-extended outer stride. The inner stride is not added on that step.
- R6: In one-dimensional mode (cfg_two_d = 0) exactly inner-count elements are issued, and the outer count and stride are ignored. An outer count of zero is then accepted.
- R7: In two-dimensional mode exactly inner-count × outer-count elements are issued before the transfer completes.
- R8: With cfg_irq_row set, irq_row pulses for one cycle in the cycle after the last element of each row is accepted, including the final row.
- R9: With cfg_irq_end set, irq_end pulses for one cycle in the cycle after the final element of the transfer is accepted. Both interrupt enables may be set together.
- R10: In single-shot mode (cfg_auto = 0), the cycle after the final element is accepted, done is high, busy and addr_valid are low, and addr holds the final element's address until the next start.
- R11: In circular mode (cfg_auto = 1), the address after the final element is the start address again, offered in the very next cycle, and done stays low.
- R12: addr_valid is high only while busy and enable are both high. With enable low nothing advances. While addr_valid is high and addr_ready is low, addr is unchanged in the next cycle.
- R13: Address arithmetic wraps modulo 2^32 without any error indication.
- R14: A start pulse while busy is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture configuration and begin (when not busy) |
| enable | input | 1 | Level gate; low pauses at an element boundary |
| cfg_base | input | 32 | Start address |
| cfg_xcnt | input | 16 | Elements per row |
| cfg_xmod | input | 16 | Signed byte stride inside a row |
| cfg_ycnt | input | 16 | Number of rows (2D only) |
| cfg_ymod | input | 16 | Signed byte stride at a row end |
| cfg_size | input | 2 | Element size code |
| cfg_two_d | input | 1 | 1 = two-dimensional transfer |
| cfg_auto | input | 1 | 1 = circular reload, 0 = single shot |
| cfg_irq_row | input | 1 | Enable the row-complete interrupt |
| cfg_irq_end | input | 1 | Enable the transfer-complete interrupt |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Address accepted when high with addr_valid |
| addr | output | 32 | Element byte address |
| addr_size | output | 2 | Element size code of the running transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Single-shot transfer finished |
| err | output | 1 | Last start was rejected |
| irq_row | output | 1 | Row-complete pulse |
| irq_end | output | 1 | Transfer-complete pulse |

## Verification
A wrong count state shows as a stride applied one element early or late. The bench compares every accepted address with an independently stepped model, so the error is caught at the first wrong element. The interrupts and done are checked against that same model in the cycle after every handshake, so an off-by-one in row or transfer termination shows within one cycle of the affected element. Random back-pressure and enable drops expose any advance that happens without a handshake: the next offered address then differs from the model.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } elem_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/dma_ag_cfg_chk.sv
module dma_ag_cfg_chk #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] xcnt,
  input  logic [CW-1:0] ycnt,
  input  logic          two_d,
  input  logic [1:0]    size,
  output logic          ok
);
  import dma_ag_pkg::*;

  logic x_zero;
  logic y_zero;
  logic size_bad;

  always_comb begin
    x_zero   = (xcnt == '0);
    y_zero   = two_d && (ycnt == '0);
    size_bad = (elem_size_e'(size) == SZ_BAD);
    ok       = !x_zero && !y_zero && !size_bad;
  end
endmodule

// File: rtl/dma_ag_cnt.sv
module dma_ag_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/dma_ag_step.sv
module dma_ag_step #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [MW-1:0] xmod,
  input  logic [MW-1:0] ymod,
  input  logic          row_end,
  output logic [AW-1:0] nxt
);
  localparam int EXT = AW - MW;

  logic [AW-1:0] stride;

  always_comb begin
    if (row_end) begin
      stride = {{EXT{ymod[MW-1]}}, ymod};
    end else begin
      stride = {{EXT{xmod[MW-1]}}, xmod};
    end
    nxt = cur + stride;
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          enable,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_xcnt,
  input  logic [MW-1:0] cfg_xmod,
  input  logic [CW-1:0] cfg_ycnt,
  input  logic [MW-1:0] cfg_ymod,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_two_d,
  input  logic          cfg_auto,
  input  logic          cfg_irq_row,
  input  logic          cfg_irq_end,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic [1:0]    addr_size,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          irq_row,
  output logic          irq_end
);
  import dma_ag_pkg::*;

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  run_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] base_q;
  logic [CW-1:0] xcnt_q, ycnt_q;
  logic [MW-1:0] xmod_q, ymod_q;
  logic [1:0]    size_q;
  logic          auto_q, irqr_en_q, irqe_en_q;
  logic          err_q, err_d;
  logic          irq_row_q, irq_row_d;
  logic          irq_end_q, irq_end_d;

  logic          cfg_ok;
  logic          start_idle, start_ok, start_bad;
  logic          acc, x_last, y_last, final_elem;
  logic          addr_en;
  logic [CW-1:0] ycnt_eff;
  logic [AW-1:0] step_nxt;
  logic          xc_load, xc_dec, yc_load, yc_dec;
  logic [CW-1:0] xc_val, yc_val;

  dma_ag_cfg_chk #(.CW(CW)) u_cfg (
    .xcnt  (cfg_xcnt),
    .ycnt  (cfg_ycnt),
    .two_d (cfg_two_d),
    .size  (cfg_size),
    .ok    (cfg_ok)
  );

  always_comb begin
    start_idle = start && (st_q != ST_RUN);
    start_ok   = start_idle && cfg_ok;
    start_bad  = start_idle && !cfg_ok;
    acc        = addr_valid && addr_ready;
    final_elem = x_last && y_last;
    ycnt_eff   = cfg_two_d ? cfg_ycnt : ONE;
    xc_load    = start_ok | (acc & x_last);
    xc_val     = start_ok ? cfg_xcnt : xcnt_q;
    xc_dec     = acc & ~x_last;
    yc_load    = start_ok | (acc & final_elem & auto_q);
    yc_val     = start_ok ? ycnt_eff : ycnt_q;
    yc_dec     = acc & x_last & ~final_elem;
  end

  dma_ag_cnt #(.CW(CW)) u_xcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (xc_load),
    .dec      (xc_dec),
    .load_val (xc_val),
    .last     (x_last)
  );

  dma_ag_cnt #(.CW(CW)) u_ycnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (yc_load),
    .dec      (yc_dec),
    .load_val (yc_val),
    .last     (y_last)
  );

  dma_ag_step #(.AW(AW), .MW(MW)) u_step (
    .cur     (addr_q),
    .xmod    (xmod_q),
    .ymod    (ymod_q),
    .row_end (x_last),
    .nxt     (step_nxt)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    err_d     = err_q;
    irq_row_d = acc && x_last && irqr_en_q;
    irq_end_d = acc && final_elem && irqe_en_q;
    addr_en   = start_ok | acc;
    if (start_ok) begin
      st_d   = ST_RUN;
      addr_d = cfg_base;
      err_d  = 1'b0;
    end else if (start_bad) begin
      err_d  = 1'b1;
    end else if (acc) begin
      if (final_elem) begin
        if (auto_q) begin
          addr_d = base_q;
        end else begin
          st_d   = ST_DONE;
          addr_d = addr_q;
        end
      end else begin
        addr_d = step_nxt;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      err_q     <= 1'b0;
      irq_row_q <= 1'b0;
      irq_end_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      err_q     <= err_d;
      irq_row_q <= irq_row_d;
      irq_end_q <= irq_end_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  // configuration capture, clock-enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      xcnt_q    <= '0;
      ycnt_q    <= '0;
      xmod_q    <= '0;
      ymod_q    <= '0;
      size_q    <= '0;
      auto_q    <= 1'b0;
      irqr_en_q <= 1'b0;
      irqe_en_q <= 1'b0;
    end else if (start_ok) begin
      base_q    <= cfg_base;
      xcnt_q    <= cfg_xcnt;
      ycnt_q    <= ycnt_eff;
      xmod_q    <= cfg_xmod;
      ymod_q    <= cfg_ymod;
      size_q    <= cfg_size;
      auto_q    <= cfg_auto;
      irqr_en_q <= cfg_irq_row;
      irqe_en_q <= cfg_irq_end;
    end
  end

  assign busy       = (st_q == ST_RUN);
  assign done       = (st_q == ST_DONE);
  assign addr_valid = busy && enable;
  assign addr       = addr_q;
  assign addr_size  = size_q;
  assign err        = err_q;
  assign irq_row    = irq_row_q;
  assign irq_end    = irq_end_q;
endmodule

// File: rtl/dma_ag_chk.sv
module dma_ag_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          enable,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          irq_row,
  input logic          irq_end
);
  p_valid_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (enable && busy));

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> $stable(addr));

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !addr_valid));

  p_done_keeps_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(addr));

  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  p_row_irq_after_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_row |-> $past(addr_valid && addr_ready));

  p_end_irq_after_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> $past(addr_valid && addr_ready));

  p_start_busy_ignored_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(addr_valid && addr_ready)) |=> busy);
endmodule

bind dma_addr_gen dma_ag_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .enable     (enable),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr       (addr),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .irq_row    (irq_row),
  .irq_end    (irq_end)
);

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;
  logic        clk;
  logic        rst_n;
  logic        start, enable;
  logic [31:0] cfg_base;
  logic [15:0] cfg_xcnt, cfg_xmod, cfg_ycnt, cfg_ymod;
  logic [1:0]  cfg_size;
  logic        cfg_two_d, cfg_auto, cfg_irq_row, cfg_irq_end;
  logic        addr_valid, addr_ready;
  logic [31:0] addr;
  logic [1:0]  addr_size;
  logic        busy, done, err, irq_row, irq_end;

  int checks = 0;
  int errors = 0;

  dma_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
    .cfg_base(cfg_base), .cfg_xcnt(cfg_xcnt), .cfg_xmod(cfg_xmod),
    .cfg_ycnt(cfg_ycnt), .cfg_ymod(cfg_ymod), .cfg_size(cfg_size),
    .cfg_two_d(cfg_two_d), .cfg_auto(cfg_auto), .cfg_irq_row(cfg_irq_row),
    .cfg_irq_end(cfg_irq_end), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr), .addr_size(addr_size), .busy(busy), .done(done), .err(err),
    .irq_row(irq_row), .irq_end(irq_end)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; enable = 1'b1; addr_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] base, input int xc, input int yc,
                         input logic [15:0] xm, input logic [15:0] ym, input logic [1:0] sz,
                         input bit td, input bit au, input bit ir, input bit ie);
    cfg_base = base; cfg_xcnt = 16'(xc); cfg_ycnt = 16'(yc);
    cfg_xmod = xm; cfg_ymod = ym; cfg_size = sz;
    cfg_two_d = td; cfg_auto = au; cfg_irq_row = ir; cfg_irq_end = ie;
  endtask

  // Rejected start: err high, nothing offered (R2)
  task automatic bad_start(input int xc, input int yc, input bit td, input logic [1:0] sz);
    set_cfg(32'h40, xc, yc, 16'd4, 16'd4, sz, td, 1'b0, 1'b0, 1'b0);
    enable = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R2 err after bad start", {31'd0, err}, 32'd1);
    chk(busy == 1'b0 && addr_valid == 1'b0, "R2 no run after bad start", {30'd0, busy, addr_valid}, 32'd0);
  endtask

  task automatic run_xfer(input logic [31:0] base, input int xc, input int yc,
                          input logic [15:0] xm, input logic [15:0] ym, input logic [1:0] sz,
                          input bit td, input bit au, input bit ir, input bit ie,
                          input int rdy_pct, input int en_pct, input bit mid_start, input string tag);
    int ylim, n, target, acc, mx, my, cyc, gaps;
    logic [31:0] m_addr, hold_addr;
    bit exp_row, exp_end, hold_pending, row_last, fin;
    ylim = td ? yc : 1;
    n = xc * ylim;
    target = au ? (2 * n + 2) : n;
    set_cfg(base, xc, yc, xm, ym, sz, td, au, ir, ie);
    enable = 1'b1; addr_ready = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R3 busy after start ", tag}, {31'd0, busy}, 32'd1);
    chk(addr == base, {"R3 first address ", tag}, addr, base);
    chk(addr_size == sz, {"R3 size code ", tag}, {30'd0, addr_size}, {30'd0, sz});
    chk(err == 1'b0, {"R2 err cleared by good start ", tag}, {31'd0, err}, 32'd0);
    m_addr = base; mx = 0; my = 0; acc = 0; cyc = 0; gaps = 0;
    exp_row = 0; exp_end = 0; hold_pending = 0; hold_addr = '0;
    while (acc < target && cyc < 5000) begin
      chk(irq_row == exp_row, {"R8 irq_row ", tag}, {31'd0, irq_row}, {31'd0, exp_row});
      chk(irq_end == exp_end, {"R9 irq_end ", tag}, {31'd0, irq_end}, {31'd0, exp_end});
      if (!au) chk(done == 1'b0, {"R7 no early done ", tag}, {31'd0, done}, 32'd0);
      if (hold_pending) chk(addr == hold_addr, {"R12 stalled address held ", tag}, addr, hold_addr);
      exp_row = 0; exp_end = 0; hold_pending = 0;
      enable = ($urandom % 100) < en_pct;
      addr_ready = ($urandom % 100) < rdy_pct;
      if (mid_start && cyc == 2) begin
        start = 1'b1; cfg_base = ~base; cfg_xcnt = 16'd1;
      end
      #1;
      if (!enable) chk(addr_valid == 1'b0, {"R12 valid gated by enable ", tag}, {31'd0, addr_valid}, 32'd0);
      if (addr_valid && addr_ready) begin
        chk(addr == m_addr, {"R4 R5 R13 element address ", tag}, addr, m_addr);
        row_last = (mx == xc - 1);
        fin = row_last && (my == ylim - 1);
        exp_row = ir && row_last;
        exp_end = ie && fin;
        if (fin) begin
          if (au) m_addr = base;
          mx = 0; my = 0;
        end else if (row_last) begin
          m_addr = m_addr + sext(ym); mx = 0; my++;
        end else begin
          m_addr = m_addr + sext(xm); mx++;
        end
        acc++;
      end else begin
        if (addr_valid) begin hold_pending = 1; hold_addr = addr; end
        if (enable) gaps++;
      end
      @(negedge clk);
      start = 1'b0; cfg_base = base; cfg_xcnt = 16'(xc);
      cyc++;
    end
    chk(acc == target, {"R6 R7 element count ", tag}, 32'(acc), 32'(target));
    chk(irq_row == exp_row, {"R8 final irq_row ", tag}, {31'd0, irq_row}, {31'd0, exp_row});
    chk(irq_end == exp_end, {"R9 final irq_end ", tag}, {31'd0, irq_end}, {31'd0, exp_end});
    if (!au) begin
      enable = 1'b1;
      #1;
      chk(done == 1'b1 && busy == 1'b0 && addr_valid == 1'b0, {"R10 stopped ", tag},
          {29'd0, done, busy, addr_valid}, 32'd4);
      chk(addr == m_addr, {"R10 final address held ", tag}, addr, m_addr);
      @(negedge clk);
      chk(addr == m_addr && done == 1'b1, {"R10 still held ", tag}, addr, m_addr);
    end else begin
      chk(done == 1'b0, {"R11 no done in circular ", tag}, {31'd0, done}, 32'd0);
      if (rdy_pct >= 100 && en_pct >= 100)
        chk(gaps == 0, {"R11 no idle cycle at reload ", tag}, 32'(gaps), 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    set_cfg(32'h0, 1, 1, 16'd0, 16'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_reset();
    chk({addr_valid, busy, done, err, irq_row, irq_end} == 6'd0, "R1 reset outputs",
        {26'd0, addr_valid, busy, done, err, irq_row, irq_end}, 32'd0);

    // rotation-style 2D pattern with negative outer stride
    run_xfer(32'h100, 4, 4, 16'd4, 16'hFFF3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 100, 100, 1'b0, "rotate");
    // zero inner stride fill, 32-bit elements
    run_xfer(32'h2000, 8, 3, 16'd0, 16'd7, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 100, 100, 1'b0, "fill R4");
    // wrap past the top of the address space
    run_xfer(32'hFFFF_FFF8, 4, 1, 16'd4, 16'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 100, 100, 1'b0, "wrap R13");
    // 1D with a zero outer count is legal
    run_xfer(32'h3000, 5, 0, 16'd2, 16'h8000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 100, 100, 1'b0, "1D R6");
    // rejected starts, then a good one clears err
    bad_start(0, 3, 1'b1, 2'd0);
    chk(done == 1'b1, "R2 done kept after bad start", {31'd0, done}, 32'd1);
    bad_start(3, 0, 1'b1, 2'd0);
    bad_start(3, 3, 1'b1, 2'd3);
    run_xfer(32'h500, 2, 2, 16'd1, 16'd10, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 100, 100, 1'b0, "after err R2");
    // back-pressure, enable drops and a start while busy
    run_xfer(32'h800, 3, 3, 16'hFFFC, 16'd40, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 40, 70, 1'b1, "stall R12 R14");
    // circular mode
    do_reset();
    run_xfer(32'h9000, 3, 2, 16'd4, 16'd100, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 100, 100, 1'b0, "circ R11");
    do_reset();
    run_xfer(32'hA000, 1, 1, 16'd4, 16'd4, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 100, 100, 1'b0, "circ1 R11");
    do_reset();
    run_xfer(32'hB000, 2, 3, 16'd8, 16'hFFF0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 60, 80, 1'b0, "circ stall R11");
    do_reset();

    for (int i = 0; i < 30; i++) begin
      int xc, yc, xmi, ymi;
      xc  = 1 + int'($urandom % 6);
      yc  = 1 + int'($urandom % 4);
      xmi = int'($urandom % 81) - 40;
      ymi = int'($urandom % 81) - 40;
      if (i % 5 == 0) xmi = 0;
      run_xfer($urandom, xc, yc, 16'(xmi), 16'(ymi), 2'($urandom % 3), 1'($urandom),
               1'b0, 1'($urandom), 1'($urandom), 60 + int'($urandom % 41),
               70 + int'($urandom % 31), 1'b0, "random R4 R5 R7");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule